// File: doc/BRIEF.md
# Transmit FIFO Error Interrupt Unit

This unit collects error events from a four-port transmit controller. Each port has two ECC-protected FIFOs: a store-and-forward FIFO and a reorder FIFO. Single-cycle event pulses come in on plain inputs. The unit makes them sticky in one shared status word and filters them through one shared mask word. From the result it drives a single level interrupt line towards a logical-device interrupt manager.

For each port and each FIFO, the unit also keeps a small ECC status register holding a correctable and an uncorrectable flag. Next to it sits a bank of captured data words, taken from a capture bus when the first error of that FIFO arrives. An interrupt handler reads the shared status to find the interrupting port. It then inspects that port's ECC registers and clears them by writing a command bit. Last, it clears the port's status field by writing ones across it.

All registers sit behind a simple word bus. A write takes effect at the clock edge, and read data is a combinational function of the address. Each port owns one byte of the shared words and a 256-byte page of its own registers.

Top module: `ecc_irq_unit`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask word reads 0x3F3F3F3F, every ECC status register and captured word reads zero, and `irq` is low.
- R2: Event input bit 6p+i sets status bit 8p+i for port p, and the bit stays set until it is cleared. The field order from i=0 up is: store-and-forward correctable, store-and-forward uncorrectable, reorder correctable, reorder uncorrectable, reorder error, packet-assembly dead.
- R3: A write to the status word (address 0x000) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when some status bit is set while its mask bit is 0. A mask bit of 1 blocks that event.
- R6: A write to the mask word (address 0x004) stores bits 8p..8p+5 for every port. The remaining bits of both the status and mask words read as zero.
- R7: For each port and FIFO, bit 17 of the ECC status register sets on that FIFO's correctable event and bit 16 sets on its uncorrectable event. Both flags are sticky. All other bits read zero.
- R8: A write with bit 31 set to an ECC status register clears that register and its captured words. A write with bit 31 clear has no effect.
- R9: When an ECC event reaches a FIFO whose ECC status register is zero, the unit captures CAPN words of CAPW bits from that FIFO's slice of the capture bus. Later events keep the first capture. The slice for port p, FIFO f (0 = store-and-forward, 1 = reorder) and word k starts at bit ((2p+f)·CAPN+k)·CAPW.
- R10: When a clear command and an ECC event hit the same register in the same cycle, the register holds only the new event's flag and a fresh capture.
- R11: Port p's page is at 0x400+0x100·p. Within a page, the store-and-forward ECC status is at offset 0x00 and the reorder ECC status at 0x04. Captured word k sits at 0x20+4k (store-and-forward) or 0x40+4k (reorder) for k < CAPN. Every other address, including unaligned ones, reads zero, and writes to captured words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address for both reads and writes |
| regWrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr`, combinational |
| evtIn | input | 24 | Event pulses, six per port |
| eccCapIn | input | 2·4·CAPN·CAPW | Capture bus, one slice per port and FIFO |
| irq | output | 1 | Level interrupt to the device manager |

## Verification
The properties treat `evtIn` as single-cycle pulses sampled at the clock edge. They assume that any read-back observing a write or event is issued on the following cycle. The clear-command property further assumes that no store-and-forward event for port 0 arrives in the same cycle as the clear. The directed part of the stimulus issues its reads strictly one cycle after each write or pulse. The mixed phase draws sparse pulses and random writes that may collide with events. Every such cycle is still compared against the reference model, so no property depends on the collisions being absent.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;
  localparam int NPORT   = 4;
  localparam int EVW     = 6;
  localparam int FSTRIDE = 8;
  localparam int NSLOT   = NPORT * 2;
  localparam int DW      = 32;
  localparam int AW      = 12;

  // event field positions inside one port byte
  localparam int EV_SF_COR = 0;
  localparam int EV_SF_UNC = 1;
  localparam int EV_RO_COR = 2;
  localparam int EV_RO_UNC = 3;

  localparam logic [AW-1:0] A_STS = 12'h000;
  localparam logic [AW-1:0] A_MSK = 12'h004;
  localparam logic [1:0]    PAGE_TAG = 2'b01;
  localparam int BIT_COR = 17;
  localparam int BIT_UNC = 16;
  localparam int BIT_CLR = 31;

  function automatic logic [DW-1:0] usedBits();
    logic [DW-1:0] m;
    m = '0;
    for (int p = 0; p < NPORT; p++) m[p*FSTRIDE +: EVW] = '1;
    return m;
  endfunction

  localparam logic [DW-1:0] USED = usedBits();

  typedef enum logic [2:0] {RD_NONE, RD_STS, RD_MSK, RD_ECC, RD_CAP} rdSel_e;

  typedef struct packed {
    logic                   stsWr;
    logic                   mskWr;
    logic [NPORT*EVW-1:0]   wrField;
    logic [NSLOT-1:0]       eccClr;
    rdSel_e                 rdSel;
    logic [$clog2(NSLOT)-1:0] rdSlot;
    logic [2:0]             rdIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/ecc_irq_ctl.sv
module ecc_irq_ctl import ecc_irq_pkg::*; #(
  parameter int CAPN = 5
) (
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output ctlStrobe_t    strb
);
  logic       isPage;
  logic [7:0] off;
  logic       unusedWr;

  assign isPage   = (regAddr[11:10] == PAGE_TAG);
  assign off      = regAddr[7:0];
  assign unusedWr = ^(regWrData & ~USED & ~(32'h1 << BIT_CLR));

  always_comb begin
    strb = '0;
    strb.stsWr = regWrEn && (regAddr == A_STS);
    strb.mskWr = regWrEn && (regAddr == A_MSK);
    for (int p = 0; p < NPORT; p++)
      strb.wrField[p*EVW +: EVW] = regWrData[p*FSTRIDE +: EVW];
    for (int s = 0; s < NSLOT; s++)
      strb.eccClr[s] = regWrEn && regWrData[BIT_CLR] && isPage &&
                       (regAddr[9:8] == 2'(s / 2)) &&
                       (off == ((s % 2) == 1 ? 8'h04 : 8'h00));
    strb.rdSlot = {regAddr[9:8], 1'b0};
    strb.rdIdx  = off[4:2];
    strb.rdSel  = RD_NONE;
    if (regAddr == A_STS) strb.rdSel = RD_STS;
    else if (regAddr == A_MSK) strb.rdSel = RD_MSK;
    else if (isPage && (off == 8'h00 || off == 8'h04)) begin
      strb.rdSel  = RD_ECC;
      strb.rdSlot = {regAddr[9:8], off[2]};
    end else if (isPage && off[1:0] == 2'b00 &&
                 (off[7:5] == 3'd1 || off[7:5] == 3'd2) &&
                 int'(off[4:2]) < CAPN) begin
      strb.rdSel  = RD_CAP;
      strb.rdSlot = {regAddr[9:8], off[6]};
    end
  end
endmodule

// File: rtl/ecc_irq_slot.sv
module ecc_irq_slot #(
  parameter int CAPN = 5,
  parameter int CAPW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clrCmd,
  input  logic                 evCor,
  input  logic                 evUnc,
  input  logic [CAPN*CAPW-1:0] capIn,
  input  logic [2:0]           rdIdx,
  output logic [1:0]           flags,
  output logic [CAPW-1:0]      capOut
);
  logic [CAPN-1:0][CAPW-1:0] cap;
  logic                      fresh;
  logic                      anyEv;

  assign anyEv = evCor || evUnc;
  assign fresh = clrCmd || (flags == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= 2'b00;
      cap   <= '0;
    end else begin
      if (clrCmd) flags <= {evCor, evUnc};
      else        flags <= flags | {evCor, evUnc};
      if (anyEv && fresh) cap <= capIn;
      else if (clrCmd)    cap <= '0;
    end
  end

  always_comb begin
    capOut = '0;
    for (int k = 0; k < CAPN; k++)
      if (rdIdx == 3'(k)) capOut = cap[k];
  end
endmodule

// File: rtl/ecc_irq_dp.sv
module ecc_irq_dp import ecc_irq_pkg::*; #(
  parameter int CAPN = 5,
  parameter int CAPW = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctlStrobe_t                 strb,
  input  logic [NPORT*EVW-1:0]       evtIn,
  input  logic [NSLOT*CAPN*CAPW-1:0] eccCapIn,
  output logic [DW-1:0]              rdData,
  output logic                       irq
);
  localparam int SLICE = CAPN * CAPW;

  logic [EVW-1:0]  sts   [NPORT];
  logic [EVW-1:0]  msk   [NPORT];
  logic [1:0]      flags [NSLOT];
  logic [CAPW-1:0] capRd [NSLOT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [EVW-1:0] evt;
    logic [EVW-1:0] clrBits;
    assign evt     = evtIn[p*EVW +: EVW];
    assign clrBits = strb.stsWr ? strb.wrField[p*EVW +: EVW] : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        sts[p] <= '0;
        msk[p] <= '1;
      end else begin
        sts[p] <= (sts[p] & ~clrBits) | evt;
        if (strb.mskWr) msk[p] <= strb.wrField[p*EVW +: EVW];
      end
    end

    for (genvar f = 0; f < 2; f++) begin : g_fifo
      localparam int S = 2 * p + f;
      ecc_irq_slot #(.CAPN(CAPN), .CAPW(CAPW)) uSlot (
        .clk    (clk),
        .rst    (rst),
        .clrCmd (strb.eccClr[S]),
        .evCor  (evt[f == 0 ? EV_SF_COR : EV_RO_COR]),
        .evUnc  (evt[f == 0 ? EV_SF_UNC : EV_RO_UNC]),
        .capIn  (eccCapIn[S*SLICE +: SLICE]),
        .rdIdx  (strb.rdIdx),
        .flags  (flags[S]),
        .capOut (capRd[S])
      );
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int p = 0; p < NPORT; p++) irq = irq | (|(sts[p] & ~msk[p]));
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_STS: for (int p = 0; p < NPORT; p++) rdData[p*FSTRIDE +: EVW] = sts[p];
      RD_MSK: for (int p = 0; p < NPORT; p++) rdData[p*FSTRIDE +: EVW] = msk[p];
      RD_ECC: begin
        rdData[BIT_COR] = flags[strb.rdSlot][1];
        rdData[BIT_UNC] = flags[strb.rdSlot][0];
      end
      RD_CAP: rdData[CAPW-1:0] = capRd[strb.rdSlot];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ecc_irq_unit.sv
module ecc_irq_unit import ecc_irq_pkg::*; #(
  parameter int CAPN = 5,
  parameter int CAPW = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       regWrEn,
  input  logic [AW-1:0]              regAddr,
  input  logic [DW-1:0]              regWrData,
  output logic [DW-1:0]              rdData,
  input  logic [NPORT*EVW-1:0]       evtIn,
  input  logic [NSLOT*CAPN*CAPW-1:0] eccCapIn,
  output logic                       irq
);
  ctlStrobe_t strb;

  ecc_irq_ctl #(.CAPN(CAPN)) uCtl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  ecc_irq_dp #(.CAPN(CAPN), .CAPW(CAPW)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .evtIn    (evtIn),
    .eccCapIn (eccCapIn),
    .rdData   (rdData),
    .irq      (irq)
  );
endmodule

// File: rtl/ecc_irq_chk.sv
module ecc_irq_chk import ecc_irq_pkg::*; (
  input logic                 clk,
  input logic                 rst,
  input logic                 regWrEn,
  input logic [AW-1:0]        regAddr,
  input logic [DW-1:0]        regWrData,
  input logic [DW-1:0]        rdData,
  input logic [NPORT*EVW-1:0] evtIn,
  input logic                 irq
);
  function automatic logic [DW-1:0] spread(logic [NPORT*EVW-1:0] e);
    logic [DW-1:0] r;
    r = '0;
    for (int p = 0; p < NPORT; p++) r[p*FSTRIDE +: EVW] = e[p*EVW +: EVW];
    return r;
  endfunction

  // R2 and R4: a pulse is visible in the status word on the next cycle, even against a clear
  p_evt_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (evtIn != '0) ##1 (regAddr == A_STS) |->
      ((rdData & spread($past(evtIn))) == spread($past(evtIn))));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == A_STS && evtIn == '0) ##1 (regAddr == A_STS) |->
      ((rdData & $past(regWrData) & USED) == '0));

  p_full_mask_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == A_MSK && (regWrData & USED) == USED) |=> !irq);

  p_unused_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (regAddr == A_STS || regAddr == A_MSK) |-> ((rdData & ~USED) == '0));

  p_ecc_bits_only_r7: assert property (@(posedge clk) disable iff (rst)
    (regAddr[11:10] == PAGE_TAG && regAddr[7:3] == '0 && regAddr[1:0] == 2'b00) |->
      ((rdData & ~32'h0003_0000) == '0));

  p_ecc_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regWrData[BIT_CLR] && regAddr == 12'h400 && evtIn[1:0] == 2'b00)
      ##1 (regAddr == 12'h400) |-> (rdData == '0));

  p_hole_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 12'h008 || regAddr[1:0] != 2'b00) |-> (rdData == '0));
endmodule

bind ecc_irq_unit ecc_irq_chk uChk (
  .clk       (clk),
  .rst       (rst),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .rdData    (rdData),
  .evtIn     (evtIn),
  .irq       (irq)
);

// File: tb/ecc_irq_unit_test.sv
module ecc_irq_unit_test;
  localparam int NP = 4;
  localparam int CN = 5;
  localparam int CW = 16;
  localparam int BUSW = NP * 2 * CN * CW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            regWrEn = 1'b0;
  logic [11:0]     regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     rdData;
  logic [23:0]     evtIn = '0;
  logic [BUSW-1:0] eccCapIn = '0;
  logic            irq;

  logic [BUSW-1:0] capBus = '0;
  int nChk = 0;
  int nErr = 0;

  // reference state
  logic [5:0]    mSts [NP];
  logic [5:0]    mMsk [NP];
  logic [1:0]    mEcc [NP][2];
  logic [CW-1:0] mCap [NP][2][CN];

  always #5 clk = ~clk;   // 10 ns period

  ecc_irq_unit #(.CAPN(CN), .CAPW(CW)) uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdData(rdData), .evtIn(evtIn),
    .eccCapIn(eccCapIn), .irq(irq)
  );

  function automatic logic [31:0] mRead(logic [11:0] a);
    logic [31:0] r;
    int p, off;
    r = '0;
    if (a == 12'h000) begin
      for (int q = 0; q < NP; q++) r[8*q +: 6] = mSts[q];
    end else if (a == 12'h004) begin
      for (int q = 0; q < NP; q++) r[8*q +: 6] = mMsk[q];
    end else if (a[11:10] == 2'b01) begin
      p = int'(a[9:8]);
      off = int'(a[7:0]);
      if (off == 0 || off == 4) begin
        r[17] = mEcc[p][off/4][1];
        r[16] = mEcc[p][off/4][0];
      end else if (off % 4 == 0 && off >= 32 && off < 32 + 4*CN)
        r[CW-1:0] = mCap[p][0][(off-32)/4];
      else if (off % 4 == 0 && off >= 64 && off < 64 + 4*CN)
        r[CW-1:0] = mCap[p][1][(off-64)/4];
    end
    return r;
  endfunction

  function automatic logic mIrq();
    logic r;
    r = 1'b0;
    for (int q = 0; q < NP; q++) if ((mSts[q] & ~mMsk[q]) != 0) r = 1'b1;
    return r;
  endfunction

  function automatic void mUpdate(logic [23:0] evt, logic wr, logic [11:0] a, logic [31:0] d);
    for (int p = 0; p < NP; p++) begin
      logic [5:0] e, clr;
      e = evt[6*p +: 6];
      clr = (wr && a == 12'h000) ? d[8*p +: 6] : 6'h0;
      mSts[p] = (mSts[p] & ~clr) | e;
      if (wr && a == 12'h004) mMsk[p] = d[8*p +: 6];
      for (int f = 0; f < 2; f++) begin
        logic [1:0] ev;
        logic cc, empty;
        ev = {e[2*f], e[2*f+1]};
        cc = wr && d[31] && (a == 12'(12'h400 + 256*p + 4*f));
        empty = cc || (mEcc[p][f] == 2'b00);
        if (cc) begin
          mEcc[p][f] = 2'b00;
          for (int k = 0; k < CN; k++) mCap[p][f][k] = '0;
        end
        if (ev != 2'b00 && empty)
          for (int k = 0; k < CN; k++) mCap[p][f][k] = capBus[((2*p+f)*CN+k)*CW +: CW];
        mEcc[p][f] = mEcc[p][f] | ev;
      end
    end
  endfunction

  task automatic tick(string req, logic [23:0] evt, logic wr, logic [11:0] a, logic [31:0] d);
    logic [31:0] expRd;
    logic expIrq;
    @(negedge clk);
    evtIn = evt; regWrEn = wr; regAddr = a; regWrData = d; eccCapIn = capBus;
    #1;
    expRd = mRead(a);
    expIrq = mIrq();
    nChk++;
    if (rdData !== expRd || irq !== expIrq) begin
      nErr++;
      $display("FAIL %s: addr %h rdData %h irq %b, expected rdData %h irq %b",
               req, a, rdData, irq, expRd, expIrq);
    end
    @(posedge clk);
    mUpdate(evt, wr, a, d);
  endtask

  task automatic rd(string req, logic [11:0] a);
    tick(req, 24'h0, 1'b0, a, 32'h0);
  endtask

  task automatic wr(string req, logic [11:0] a, logic [31:0] d);
    tick(req, 24'h0, 1'b1, a, d);
  endtask

  task automatic setCap(int seed);
    for (int s = 0; s < 2*NP; s++)
      for (int k = 0; k < CN; k++)
        capBus[(s*CN+k)*CW +: CW] = CW'(seed*131 + s*17 + k*3 + 1);
  endtask

  initial begin
    #2_000_000;
    nErr++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      mSts[p] = '0; mMsk[p] = '1;
      for (int f = 0; f < 2; f++) begin
        mEcc[p][f] = '0;
        for (int k = 0; k < CN; k++) mCap[p][f][k] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    rd("R1 status", 12'h000);
    rd("R1 mask", 12'h004);
    rd("R1 ecc sf p0", 12'h400);
    rd("R1 capture word", 12'h720);

    // R2 field order and port stride, masked so R5 keeps irq low
    tick("R2 sf cor p0", 24'h000001, 1'b0, 12'h000, 0);
    tick("R2 dead p3", 24'h800000, 1'b0, 12'h000, 0);
    tick("R2 ro cor p1", 24'h000100, 1'b0, 12'h000, 0);
    tick("R2 ro err p2", 24'h010000, 1'b0, 12'h000, 0);
    rd("R5 all masked", 12'h000);

    // R6 mask write and unused bits
    wr("R6 mask all", 12'h004, 32'hFFFF_FFFF);
    rd("R6 mask read", 12'h004);
    wr("R5 unmask p0 bit0", 12'h004, 32'hFFFF_FFFE);
    rd("R5 irq high", 12'h000);

    // R3 write-1-to-clear
    wr("R3 zero write", 12'h000, 32'h0000_0000);
    wr("R3 unset bit", 12'h000, 32'h0000_0002);
    wr("R3 clear bit0", 12'h000, 32'h0000_0001);
    rd("R3 irq low", 12'h000);

    // R4 event wins over clear
    wr("R4 unmask p0 bit3", 12'h004, 32'hFFFF_FFF7);
    tick("R4 set", 24'h000008, 1'b0, 12'h000, 0);
    tick("R4 collide", 24'h000008, 1'b1, 12'h000, 32'h0000_0008);
    rd("R4 still set", 12'h000);
    wr("R4 clear alone", 12'h000, 32'h0000_0008);
    rd("R4 cleared", 12'h000);

    // R7 / R9 capture on first error of port 1 store-and-forward
    setCap(7);
    tick("R7 sf cor p1", 24'h000040, 1'b0, 12'h500, 0);
    rd("R7 flag", 12'h500);
    for (int k = 0; k < CN; k++) rd("R9 capture", 12'(12'h520 + 4*k));
    setCap(9);
    tick("R7 sf unc p1", 24'h000080, 1'b0, 12'h500, 0);
    rd("R7 both flags", 12'h500);
    rd("R9 held first", 12'h520);
    rd("R9 held last", 12'h530);

    // R8 clear command
    wr("R8 no cmd bit", 12'h500, 32'h0003_0000);
    rd("R8 unchanged", 12'h500);
    wr("R8 clear", 12'h500, 32'h8000_0000);
    rd("R8 cleared", 12'h500);
    rd("R8 data cleared", 12'h524);

    // R10 clear and event together on port 2 reorder
    tick("R10 ro cor p2", 24'h004000, 1'b0, 12'h604, 0);
    setCap(21);
    tick("R10 collide", 24'h008000, 1'b1, 12'h604, 32'h8000_0000);
    rd("R10 new flag", 12'h604);
    rd("R10 fresh data", 12'h640);
    rd("R10 fresh data end", 12'h650);

    // R11 holes and read-only words
    rd("R11 hole", 12'h008);
    rd("R11 page hole", 12'h410);
    rd("R11 beyond CAPN", 12'h534);
    rd("R11 unaligned", 12'h001);
    wr("R11 write capture", 12'h640, 32'h0000_FFFF);
    rd("R11 capture kept", 12'h640);

    // mixed traffic against the reference model
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [23:0] e;
      int p, sel, k;
      p = int'($urandom % 4);
      sel = int'($urandom % 8);
      k = int'($urandom % CN);
      case (sel)
        0: a = 12'h000;
        1: a = 12'h004;
        2: a = 12'(12'h400 + 256*p);
        3: a = 12'(12'h404 + 256*p);
        4: a = 12'(12'h420 + 256*p + 4*k);
        5: a = 12'(12'h440 + 256*p + 4*k);
        6: a = 12'h008;
        default: a = 12'h000;
      endcase
      e = 24'($urandom & $urandom & $urandom);
      if (i % 5 == 0) setCap(i);
      tick("R9 mixed traffic", e, ($urandom % 3) == 0, a, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end
endmodule